// File: doc/BRIEF.md
# Serially Loaded Programmable Feedback Divider

This block divides a system clock by a 16-bit ratio N. The ratio arrives over a three-wire serial port: data, a serial clock, and an active-low enable. A reference-path down-counter runs beside the feedback counter. Its width is fixed and its ratio comes in on a static input. The block raises one terminal pulse per N system clocks on the feedback path, and one per R clocks on the reference path.

A frame is taken as complete only when exactly sixteen bits arrive while enable is low. The word takes effect when enable rises. The load event then crosses into the system clock domain. If the word is a legal ratio, the block adopts it and restarts both counters in the same clock cycle, so the two paths begin counting down from a common instant. Ratios below forty are rejected. The old ratio stays, the counters run on undisturbed, and a one-cycle flag reports the rejection.

Top module: `fbdiv_serial_top`

## Requirements
- R1: While `rst` is high on a rising `clk` edge, `n_ratio` becomes `N_RESET` (default 100), `illegal_value` clears, the feedback counter loads `N_RESET` and the reference counter loads `r_div`. After reset is released, the first `n_pulse` comes `N_RESET`-1 clocks after the last reset edge.
- R2: Serial bits are sampled on the rising edge of `ser_clk` only while `ser_en_n` is low. They are shifted in most significant bit first, so the first bit of the frame ends up at bit 15 of the ratio.
- R3: The rising edge of `ser_en_n` commits the frame only when exactly 16 bits were sampled since enable fell. A frame with any other bit count changes neither the ratio nor the counters, and raises no flag.
- R4: A committed word below 40 (0x0000 to 0x0027) leaves `n_ratio` unchanged and does not restart either counter. `illegal_value` is high for exactly one `clk` cycle.
- R5: A committed word from 40 to 65535 becomes `n_ratio`. From then on `n_pulse` is high for one clock in every N clocks.
- R6: `r_pulse` is high for one clock in every R clocks, where R is `r_div`. The values 0 and 1 both give a period of one clock.
- R7: On a legal load, both counters are jam-loaded on the same edge that updates `n_ratio`. Neither pulse is high in that cycle. The first `n_pulse` follows N-1 clocks later and the first `r_pulse` follows R-1 clocks later.
- R8: The load event passes through a two-flop synchronizer and an edge detector. When `ser_en_n` rises between two `clk` edges, `n_ratio` (or `illegal_value`) changes on the third rising `clk` edge after that rise.
- R9: When a jam-load lands on the edge where a counter would reload from its terminal count, the jam value wins. The terminal pulse in the cycle before that edge is still emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the frequency being divided |
| rst | input | 1 | Synchronous active-high reset; the serial side also resets on its own edges |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_en_n | input | 1 | Active-low frame enable; its rising edge commits the frame |
| r_div | input | R_W (14) | Reference-path ratio |
| n_pulse | output | 1 | One-clock terminal pulse of the feedback counter |
| r_pulse | output | 1 | One-clock terminal pulse of the reference counter |
| illegal_value | output | 1 | One-clock flag: a committed ratio was below 40 |
| n_ratio | output | 16 | Ratio currently in use by the feedback counter |

## Verification
Two functions can act on the same clock edge: a jam-load arriving from the serial side, and a counter's own reload from terminal count. To provoke this, the bench predicts the next feedback pulse. It then times the rise of enable so that the synchronized load lands exactly on the reload edge. The scoreboard then requires three things. The pulse in the preceding cycle must still be present. The new ratio must appear on the predicted edge. The next pulses must fall N-1 and R-1 clocks later, not one period after the abandoned reload.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    localparam int unsigned RATIO_W    = 16;
    localparam int unsigned FRAME_BITS = 16;
    localparam logic [RATIO_W-1:0] RATIO_FLOOR = 16'd40;

    typedef logic [RATIO_W-1:0] ratio_t;

    // Load event as seen in the divider clock domain
    typedef struct packed {
        logic   apply;   // legal word: adopt and jam both counters
        logic   reject;  // word below the floor: flag only
        ratio_t ratio;
    } load_evt_t;

    function automatic logic ratio_legal(input ratio_t v);
        return v >= RATIO_FLOOR;
    endfunction

endpackage

// File: rtl/fbdiv_serial_rx.sv
module fbdiv_serial_rx
    import fbdiv_pkg::*;
(
    input  logic   rst,
    input  logic   ser_clk,
    input  logic   ser_data,
    input  logic   ser_en_n,
    output ratio_t word,
    output logic   ld_tog
);

    localparam int unsigned CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

    ratio_t           shreg;
    logic [CNT_W-1:0] bcnt;
    logic             seen_tok;
    logic             frame_tok;
    logic             frame_ok;

    // Shift side: a token mismatch marks the first bit of a new frame
    always_ff @(posedge ser_clk) begin
        if (rst) begin
            shreg    <= '0;
            bcnt     <= '0;
            seen_tok <= 1'b0;
        end else if (!ser_en_n) begin
            if (seen_tok != frame_tok) begin
                shreg    <= {{(RATIO_W-1){1'b0}}, ser_data};
                bcnt     <= CNT_W'(1);
                seen_tok <= frame_tok;
            end else begin
                shreg <= {shreg[RATIO_W-2:0], ser_data};
                if (bcnt != CNT_SAT) begin
                    bcnt <= bcnt + 1'b1;
                end
            end
        end
    end

    assign frame_ok = (bcnt == CNT_FULL) && (seen_tok == frame_tok);

    // Commit side: runs on the closing edge of the enable
    always_ff @(posedge ser_en_n) begin
        if (rst) begin
            frame_tok <= 1'b0;
            ld_tog    <= 1'b0;
            word      <= '0;
        end else begin
            frame_tok <= ~frame_tok;
            if (frame_ok) begin
                word   <= shreg;
                ld_tog <= ~ld_tog;
            end
        end
    end

endmodule

// File: rtl/fbdiv_load_sync.sv
module fbdiv_load_sync
    import fbdiv_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ld_tog,
    input  ratio_t    word,
    output load_evt_t evt
);

    localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic               toggled;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], ld_tog};
        end
    end

    assign toggled = chain_q[CHAIN_W-1] ^ chain_q[CHAIN_W-2];

    always_comb begin
        evt.ratio  = word;
        evt.apply  = toggled && ratio_legal(word);
        evt.reject = toggled && !ratio_legal(word);
    end

    // R8
    single_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.apply || evt.reject) |=> !(evt.apply || evt.reject));

endmodule

// File: rtl/fbdiv_downcnt.sv
module fbdiv_downcnt #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         jam,
    input  logic [W-1:0] jam_val,
    input  logic [W-1:0] reload_val,
    output logic         tc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] jam_fl;
    logic [W-1:0] reload_fl;

    // Ratios of zero behave as divide-by-one
    assign jam_fl    = (jam_val == '0)    ? ONE : jam_val;
    assign reload_fl = (reload_val == '0) ? ONE : reload_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= reload_fl;
        end else if (jam) begin
            cnt <= jam_fl;
        end else if (cnt <= ONE) begin
            cnt <= reload_fl;
        end else begin
            cnt <= cnt - ONE;
        end
    end

    assign tc = (cnt == ONE);

    // R5
    tc_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tc && !jam) |=> (cnt == $past(reload_fl)));

    // R9
    jam_priority_chk: assert property (@(posedge clk) disable iff (rst)
        jam |=> (cnt == $past(jam_fl)));

endmodule

// File: rtl/fbdiv_serial_top.sv
module fbdiv_serial_top
    import fbdiv_pkg::*;
#(
    parameter int unsigned R_W         = 14,
    parameter int unsigned N_RESET     = 100,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_clk,
    input  logic               ser_data,
    input  logic               ser_en_n,
    input  logic [R_W-1:0]     r_div,
    output logic               n_pulse,
    output logic               r_pulse,
    output logic               illegal_value,
    output logic [RATIO_W-1:0] n_ratio
);

    localparam ratio_t N_RESET_V = RATIO_W'(N_RESET);

    ratio_t          rx_word;
    logic            rx_tog;
    load_evt_t       evt;
    ratio_t          n_reg;
    logic            illegal_q;
    ratio_t          n_cnt;
    logic [R_W-1:0]  r_cnt;
    logic [R_W-1:0]  r_fl;

    fbdiv_serial_rx i_rx (
        .rst      (rst),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_en_n (ser_en_n),
        .word     (rx_word),
        .ld_tog   (rx_tog)
    );

    fbdiv_load_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .ld_tog (rx_tog),
        .word   (rx_word),
        .evt    (evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            n_reg     <= N_RESET_V;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= evt.reject;
            if (evt.apply) begin
                n_reg <= evt.ratio;
            end
        end
    end

    fbdiv_downcnt #(.W(RATIO_W)) i_ncnt (
        .clk        (clk),
        .rst        (rst),
        .jam        (evt.apply),
        .jam_val    (evt.ratio),
        .reload_val (rst ? N_RESET_V : n_reg),
        .tc         (n_pulse),
        .cnt        (n_cnt)
    );

    fbdiv_downcnt #(.W(R_W)) i_rcnt (
        .clk        (clk),
        .rst        (rst),
        .jam        (evt.apply),
        .jam_val    (r_div),
        .reload_val (r_div),
        .tc         (r_pulse),
        .cnt        (r_cnt)
    );

    assign n_ratio       = n_reg;
    assign illegal_value = illegal_q;
    assign r_fl          = (r_div == '0) ? R_W'(1) : r_div;

    // R4
    illegal_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_value |=> !illegal_value);

    // R4
    illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_value |-> $stable(n_ratio));

    // R5
    ratio_floor_chk: assert property (@(posedge clk) disable iff (rst)
        n_ratio >= RATIO_FLOOR);

    // R7
    dual_jam_chk: assert property (@(posedge clk) disable iff (rst)
        evt.apply |=> (n_cnt == n_ratio) && (r_cnt == $past(r_fl)));

endmodule

// File: tb/test_fbdiv_serial_top.sv
module test_fbdiv_serial_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_RST      = 100;
    localparam int R_VAL      = 57;
    localparam int R_W        = 14;

    typedef struct {
        bit     illegal;
        int     value;
        longint due;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           ser_clk = 1'b0;
    logic           ser_data = 1'b0;
    logic           ser_en_n = 1'b0;
    logic [R_W-1:0] r_div = R_W'(R_VAL);
    logic           n_pulse, r_pulse, illegal_value;
    logic [15:0]    n_ratio;

    exp_t   q[$];
    exp_t   mon_e;
    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    int     cur_n;
    longint next_n, next_r, last_n_pulse;
    bit     armed = 0;
    bit     done = 0;
    bit     prev_ill = 0;
    bit     r9_pending = 0;
    logic [15:0] prev_n;

    fbdiv_serial_top #(.R_W(R_W), .N_RESET(N_RST)) i_fbdiv_serial_top (
        .clk           (clk),
        .rst           (rst),
        .ser_clk       (ser_clk),
        .ser_data      (ser_data),
        .ser_en_n      (ser_en_n),
        .r_div         (r_div),
        .n_pulse       (n_pulse),
        .r_pulse       (r_pulse),
        .illegal_value (illegal_value),
        .n_ratio       (n_ratio)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic note(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Driver: shift a frame, optionally align the commit to a terminal reload
    task automatic send_frame(input logic [31:0] bits, input int nb, input bit align);
        @(negedge clk);
        ser_en_n = 1'b0;
        #1;
        for (int i = 0; i < nb; i++) begin
            ser_data = bits[nb-1-i];
            #1 ser_clk = 1'b1;
            #2 ser_clk = 1'b0;
        end
        @(negedge clk);
        if (align) begin
            while (cyc + 2 != next_n) @(negedge clk);
            r9_pending = 1;
        end
        ser_en_n = 1'b1;
        if (nb == 16) begin
            q.push_back('{illegal: (bits[15:0] < 16'd40), value: int'(bits[15:0]), due: cyc + 3});
        end
    endtask

    // Monitor and scoreboard
    always @(negedge clk) begin
        if (armed) begin
            if (n_ratio !== prev_n) begin
                if (q.size() == 0) begin
                    note(0, "R3", "unrequested ratio change", n_ratio, prev_n);
                end else begin
                    mon_e = q.pop_front();
                    note(!mon_e.illegal, "R4", "illegal word adopted", n_ratio, prev_n);
                    note(n_ratio == mon_e.value, "R2/R5", "adopted ratio", n_ratio, mon_e.value);
                    note(cyc == mon_e.due, "R8", "load latency cycle", cyc, mon_e.due);
                end
                if (r9_pending) begin
                    note(last_n_pulse == cyc - 1, "R9", "terminal pulse before jam", last_n_pulse, cyc - 1);
                    r9_pending = 0;
                end
                note(!n_pulse && !r_pulse, "R7", "pulse in jam cycle", {n_pulse, r_pulse}, 0);
                prev_n = n_ratio;
                cur_n  = int'(n_ratio);
                next_n = cyc + cur_n - 1;
                next_r = cyc + R_VAL - 1;
            end
            if (illegal_value) begin
                if (q.size() == 0) begin
                    note(0, "R4", "unrequested illegal flag", 1, 0);
                end else begin
                    mon_e = q.pop_front();
                    note(mon_e.illegal, "R4", "flag on legal word", mon_e.value, 40);
                    note(cyc == mon_e.due, "R8", "reject latency cycle", cyc, mon_e.due);
                end
                note(n_ratio == prev_n, "R4", "ratio kept on reject", n_ratio, prev_n);
            end
            if (prev_ill) begin
                note(!illegal_value, "R4", "flag width", illegal_value, 0);
            end
            prev_ill = illegal_value;
            if (n_pulse) begin
                note(cyc == next_n, "R5/R7", "n_pulse cycle", cyc, next_n);
                last_n_pulse = cyc;
                next_n = cyc + cur_n;
            end else if (cyc == next_n) begin
                note(0, "R5/R7", "missing n_pulse", cyc, next_n);
            end
            if (r_pulse) begin
                note(cyc == next_r, "R6/R7", "r_pulse cycle", cyc, next_r);
                next_r = cyc + R_VAL;
            end else if (cyc == next_r) begin
                note(0, "R6/R7", "missing r_pulse", cyc, next_r);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Reset both serial sides with their own edges while rst is high
        for (int i = 0; i < 3; i++) begin
            #2 ser_clk = 1'b1;
            #2 ser_clk = 1'b0;
        end
        #1 ser_en_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        note(n_ratio == 16'(N_RST), "R1", "reset ratio", n_ratio, N_RST);
        note(illegal_value == 1'b0, "R1", "reset flag", illegal_value, 0);
        rst = 1'b0;
        prev_n = n_ratio;
        cur_n  = N_RST;
        next_n = cyc + N_RST - 1;
        next_r = cyc + R_VAL - 1;
        armed  = 1;

        repeat (250) @(negedge clk);
        send_frame(32'h0000_00C8, 16, 0);   // 200, asymmetric bit pattern
        repeat (450) @(negedge clk);
        send_frame(32'd39, 16, 0);          // just below the floor
        repeat (100) @(negedge clk);
        send_frame(32'd40, 16, 0);          // the floor itself
        repeat (130) @(negedge clk);
        send_frame(32'd0, 16, 0);           // zero
        repeat (60) @(negedge clk);
        send_frame(32'h0000_1234, 15, 0);   // short frame
        repeat (20) @(negedge clk);
        send_frame(32'h0001_0096, 17, 0);   // long frame
        repeat (20) @(negedge clk);
        note(n_ratio == 16'd40, "R3", "ratio after odd frames", n_ratio, 40);
        note(q.size() == 0, "R3", "pending events", q.size(), 0);
        send_frame(32'd45, 16, 1);          // jam lands on reload edge
        repeat (200) @(negedge clk);
        send_frame(32'h0000_FFFF, 16, 0);   // largest ratio
        repeat (65600) @(negedge clk);
        note(n_ratio == 16'hFFFF, "R5", "largest ratio", n_ratio, 65535);
        note(q.size() == 0, "R3", "pending events at end", q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule